// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs a host-side conversion loop for an external serial analog-to-digital converter that is driven from a system clock. A conversion begins when the block raises its conversion-start output. After a fixed conversion time the block runs one full-duplex serial frame. During that frame it shifts the result word in from the converter and shifts the next control word out to it. Each direction has its own active-low frame strobe.

After the frame, the block holds the serial lines quiet and waits out two guard intervals before it raises conversion-start again. The first is a settling interval after the last serial activity. The second is an acquisition interval. That interval is measured from the falling serial-clock edge, inside the outgoing frame, on which the converter's internal acquisition begins. Each new start is placed at the later of the two limits.

The user side offers a control word, a one-cycle start request and a free-run enable. It returns each result with a one-cycle valid strobe. All timing is given as parameters in system-clock cycles, with each physical constant rounded up. The defaults target a 250 MHz clock: conversion 5.9 µs, serial clock at or below 10 MHz, acquisition 2 µs, quiet time 500 ns.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While rstN is low, convStart is 0, rxFrameN and txFrameN are 1, sclk is 1, adcDin is 0 and resultValid is 0.
- R2: When startReq or freeRun is 1 in a cycle while the block is idle, convStart is 1 from the next cycle onward for START_CYCLES cycles. The first of those cycles is the conversion-start rising edge.
- R3: rxFrameN and txFrameN fall together exactly CONV_CYCLES cycles after the conversion-start rising edge. From that edge until then, both frames stay 1 and sclk stays 1.
- R4: A frame lasts 2*SCLK_HALF*WORD_W cycles, with both frame strobes low. Each bit spends SCLK_HALF cycles with sclk at 1 and then SCLK_HALF cycles with sclk at 0. The first cycle with sclk at 0 is that bit's falling edge. Outside a frame, sclk is 1.
- R5: ctrlWord is sampled in the cycle before the frame starts. It is sent on adcDin MSB first, and bit i is driven for the whole of bit period i. adcDin is 0 outside a frame.
- R6: adcDout is captured MSB first, once per bit, in that bit's falling-edge cycle. resultValid is 1 for exactly one cycle, the cycle after the last bit's falling edge, and result then holds the captured word.
- R7: The next conversion-start rising edge comes no earlier than ACQ_CYCLES cycles after the falling edge numbered ACQ_EDGE (counting from 1, default 6) in the preceding frame.
- R8: The next conversion-start rising edge comes no earlier than QUIET_CYCLES cycles after the first cycle in which both frames have returned to 1.
- R9: A startReq seen while a conversion, frame or guard interval is in progress is held. The next conversion then starts in the first cycle that meets both R7 and R8. Several such requests produce only one start.
- R10: While freeRun is 1, each conversion starts in the first cycle that meets R7 and R8. Once freeRun is 0 and no request is held, the block returns to idle after the guard intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request for one conversion |
| freeRun | input | 1 | Restart automatically while high |
| ctrlWord | input | WORD_W | Control word sent during the next frame |
| adcDout | input | 1 | Serial result data from the converter |
| convStart | output | 1 | Conversion-start pulse; its rising edge starts a conversion |
| sclk | output | 1 | Serial clock, idle high |
| rxFrameN | output | 1 | Active-low framing strobe for the result read |
| txFrameN | output | 1 | Active-low framing strobe for the control write |
| adcDin | output | 1 | Serial control data to the converter |
| result | output | WORD_W | Last received result word |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
Take S as the cycle after the one in which a request or free-run is sampled. convStart is due in cycle S. The frame strobes fall in cycle S+CONV_CYCLES. Bit i of the frame then shows sclk high for SCLK_HALF cycles and low for SCLK_HALF cycles. resultValid is due (WORD_W-1)*2*SCLK_HALF+SCLK_HALF+1 cycles after the frame falls. The next start is due CONV_CYCLES + max(frame length + QUIET_CYCLES, falling-edge offset + ACQ_CYCLES) cycles after S. The bench derives each of these from the start time alone and compares every output in every cycle at the falling clock edge. It drives inputs one nanosecond after the rising edge, so nothing is sampled on the edge it changes. Two parameter sets are run: in one the acquisition limit sets the restart time, and in the other the quiet limit does.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_XFER,
    ST_GUARD
  } seqState_e;

  // Strobes from the sequencer control to the shift datapath
  typedef struct packed {
    logic loadCtrl;   // last conversion cycle: capture the control word
    logic shiftOut;   // last cycle of a bit: advance the transmit bit
    logic sampleIn;   // falling-edge cycle: capture one receive bit
    logic lastBit;    // falling-edge cycle of the final bit
    logic frameOn;    // frame in progress
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SCLK_HALF    = 13,
  parameter int CONV_CYCLES  = 1475,
  parameter int START_CYCLES = 25,
  parameter int ACQ_CYCLES   = 500,
  parameter int QUIET_CYCLES = 125,
  parameter int ACQ_EDGE     = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       freeRun,
  output logic       convStart,
  output logic       sclk,
  output logic       frameN,
  output seqStrobe_t strobe
);

  localparam int PH_W    = $clog2(2 * SCLK_HALF);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int CNT_MAX = (CONV_CYCLES > QUIET_CYCLES) ? CONV_CYCLES : QUIET_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int ACQ_W   = $clog2(ACQ_CYCLES + 1);

  localparam logic [PH_W-1:0]  PH_FALL   = PH_W'(SCLK_HALF);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(2 * SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] BIT_ACQ   = BIT_W'(ACQ_EDGE - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(START_CYCLES);
  localparam logic [CNT_W-1:0] QUIET_LIM = CNT_W'(QUIET_CYCLES - 1);
  localparam logic [ACQ_W-1:0] ACQ_LIM   = ACQ_W'(ACQ_CYCLES - 1);
  localparam logic [ACQ_W-1:0] ACQ_SAT   = ACQ_W'(ACQ_CYCLES);

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bitCnt;
  logic [ACQ_W-1:0] acqAge;
  logic             pend;

  logic inXfer, fallNow, bitEnd, frameEnd, acqFall, convEnd, guardMet, want, launch;

  always_comb begin
    inXfer   = (state == ST_XFER);
    fallNow  = inXfer && (ph == PH_FALL);
    bitEnd   = inXfer && (ph == PH_LAST);
    frameEnd = bitEnd && (bitCnt == BIT_LAST);
    acqFall  = fallNow && (bitCnt == BIT_ACQ);
    convEnd  = (state == ST_CONV) && (cnt == CONV_LAST);
    guardMet = (state == ST_GUARD) && (cnt >= QUIET_LIM) && (acqAge >= ACQ_LIM);
    want     = startReq || pend || freeRun;
    launch   = want && ((state == ST_IDLE) || guardMet);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ph     <= '0;
      bitCnt <= '0;
      acqAge <= '0;
      pend   <= 1'b0;
    end else begin
      pend <= launch ? 1'b0 : (pend || startReq);

      // age of the acquisition window, counted from its falling edge
      if (convEnd)                                acqAge <= '0;
      else if (acqFall)                           acqAge <= ACQ_W'(1);
      else if (acqAge != '0 && acqAge < ACQ_SAT)  acqAge <= acqAge + 1'b1;

      case (state)
        ST_IDLE: begin
          if (launch) begin
            state <= ST_CONV;
            cnt   <= '0;
          end
        end
        ST_CONV: begin
          if (convEnd) begin
            state  <= ST_XFER;
            ph     <= '0;
            bitCnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: begin
          ph <= bitEnd ? '0 : ph + 1'b1;
          if (frameEnd) begin
            state  <= ST_GUARD;
            cnt    <= '0;
            bitCnt <= '0;
          end else if (bitEnd) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_GUARD: begin
          if (guardMet) begin
            state <= launch ? ST_CONV : ST_IDLE;
            cnt   <= '0;
          end else if (cnt < QUIET_LIM) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    convStart       = (state == ST_CONV) && (cnt < PULSE_END);
    sclk            = !(inXfer && (ph >= PH_FALL));
    frameN          = !inXfer;
    strobe.loadCtrl = convEnd;
    strobe.shiftOut = bitEnd;
    strobe.sampleIn = fallNow;
    strobe.lastBit  = fallNow && (bitCnt == BIT_LAST);
    strobe.frameOn  = inXfer;
  end

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic              adcDout,
  output logic              adcDin,
  output logic [WORD_W-1:0] result,
  output logic              resultValid
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-2:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  assign rxNext = {rxShift, adcDout};
  assign adcDin = strobe.frameOn && txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift     <= '0;
      rxShift     <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      if (strobe.loadCtrl)      txShift <= ctrlWord;
      else if (strobe.shiftOut) txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (strobe.sampleIn)      rxShift <= rxNext[WORD_W-2:0];
      if (strobe.lastBit)       result  <= rxNext;
      resultValid <= strobe.lastBit;
    end
  end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SCLK_HALF    = 13,
  parameter int CONV_CYCLES  = 1475,
  parameter int START_CYCLES = 25,
  parameter int ACQ_CYCLES   = 500,
  parameter int QUIET_CYCLES = 125,
  parameter int ACQ_EDGE     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              freeRun,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic              adcDout,
  output logic              convStart,
  output logic              sclk,
  output logic              rxFrameN,
  output logic              txFrameN,
  output logic              adcDin,
  output logic [WORD_W-1:0] result,
  output logic              resultValid
);

  seqStrobe_t strobe;
  logic       frameN;

  adc_seq_ctrl #(
    .WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF), .CONV_CYCLES(CONV_CYCLES),
    .START_CYCLES(START_CYCLES), .ACQ_CYCLES(ACQ_CYCLES),
    .QUIET_CYCLES(QUIET_CYCLES), .ACQ_EDGE(ACQ_EDGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .convStart(convStart), .sclk(sclk), .frameN(frameN), .strobe(strobe)
  );

  adc_seq_datapath #(.WORD_W(WORD_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlWord(ctrlWord),
    .adcDout(adcDout), .adcDin(adcDin), .result(result), .resultValid(resultValid)
  );

  assign rxFrameN = frameN;
  assign txFrameN = frameN;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int ACQ_CYCLES   = 500,
  parameter int QUIET_CYCLES = 125,
  parameter int ACQ_EDGE     = 6
) (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic sclk,
  input logic rxFrameN,
  input logic txFrameN,
  input logic adcDin,
  input logic resultValid
);

  logic prevSclk;
  int   fallCnt;
  int   acqAge;
  int   endAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSclk <= 1'b1;
      fallCnt  <= 0;
      acqAge   <= ACQ_CYCLES;
      endAge   <= QUIET_CYCLES;
    end else begin
      prevSclk <= sclk;
      if (rxFrameN)                 fallCnt <= 0;
      else if (prevSclk && !sclk)   fallCnt <= fallCnt + 1;
      if (!rxFrameN && prevSclk && !sclk && fallCnt == ACQ_EDGE - 1) acqAge <= 1;
      else if (acqAge < ACQ_CYCLES) acqAge <= acqAge + 1;
      if (!rxFrameN)                endAge <= 0;
      else if (endAge < QUIET_CYCLES) endAge <= endAge + 1;
    end
  end

  a_r3_quiet_while_converting: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (rxFrameN && txFrameN && sclk));

  a_r4_sclk_idles_high: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameN |-> sclk);

  a_r5_din_idles_low: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameN && txFrameN) |-> !adcDin);

  a_r6_valid_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r7_acq_window_met: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> (acqAge >= ACQ_CYCLES));

  a_r8_quiet_window_met: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> (endAge >= QUIET_CYCLES));

endmodule

bind adc_conv_sequencer adc_seq_checker #(
  .ACQ_CYCLES(ACQ_CYCLES), .QUIET_CYCLES(QUIET_CYCLES), .ACQ_EDGE(ACQ_EDGE)
) u_seqChecker (
  .clk(clk), .rstN(rstN), .convStart(convStart), .sclk(sclk),
  .rxFrameN(rxFrameN), .txFrameN(txFrameN), .adcDin(adcDin),
  .resultValid(resultValid)
);

// File: tb/test_adc_conv_sequencer.sv
module seq_harness #(
  parameter int W    = 8,
  parameter int H    = 2,
  parameter int CONV = 12,
  parameter int P    = 3,
  parameter int A    = 15,
  parameter int Q    = 3
) (
  input  logic clk,
  input  logic rstN,
  output logic done
);

  localparam int FRAME    = 2 * H * W;
  localparam int EDGEPOS  = 5 * 2 * H + H;
  localparam int GAP      = ((FRAME + Q) > (EDGEPOS + A)) ? (FRAME + Q) : (EDGEPOS + A);
  localparam int VALIDPOS = (W - 1) * 2 * H + H + 1;

  logic         startReq, freeRun, adcDout;
  logic [W-1:0] ctrlWord, result;
  logic         convStart, sclk, rxFrameN, txFrameN, adcDin, resultValid;

  int checks = 0;
  int fails  = 0;

  adc_conv_sequencer #(
    .WORD_W(W), .SCLK_HALF(H), .CONV_CYCLES(CONV), .START_CYCLES(P),
    .ACQ_CYCLES(A), .QUIET_CYCLES(Q), .ACQ_EDGE(6)
  ) i_adc_conv_sequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .ctrlWord(ctrlWord), .adcDout(adcDout), .convStart(convStart), .sclk(sclk),
    .rxFrameN(rxFrameN), .txFrameN(txFrameN), .adcDin(adcDin),
    .result(result), .resultValid(resultValid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: everything follows from the last start time
  int           cyc = 0;
  int           startAt = -1000000;
  int           sampleNo = 0;
  bit           pend = 0;
  logic [W-1:0] ctrlLat = '0;
  logic [W-1:0] adcWord = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    int d, f;
    bit inFrame;
    if (!rstN) begin
      chk("R1 convStart", convStart, 0);
      chk("R1 rxFrameN", rxFrameN, 1);
      chk("R1 txFrameN", txFrameN, 1);
      chk("R1 sclk", sclk, 1);
      chk("R1 adcDin", adcDin, 0);
      chk("R1 resultValid", resultValid, 0);
      pend    = 0;
      startAt = -1000000;
      adcDout = 1'b0;
    end else begin
      d = cyc - startAt;
      f = d - CONV;
      inFrame = (f >= 0) && (f < FRAME);
      chk("R2 R7 R8 R9 R10 convStart", convStart, (d >= 0 && d < P) ? 1 : 0);
      chk("R3 R4 rxFrameN", rxFrameN, inFrame ? 0 : 1);
      chk("R3 R4 txFrameN", txFrameN, inFrame ? 0 : 1);
      chk("R3 R4 sclk", sclk, inFrame ? (((f % (2 * H)) < H) ? 1 : 0) : 1);
      chk("R5 adcDin", adcDin, inFrame ? ctrlLat[W - 1 - f / (2 * H)] : 0);
      chk("R6 resultValid", resultValid, (f == VALIDPOS) ? 1 : 0);
      if (f == VALIDPOS) chk("R6 result", result, adcWord);
      adcDout = inFrame ? adcWord[W - 1 - f / (2 * H)] : 1'b0;
      if (f == -1) ctrlLat = ctrlWord;
      if ((cyc + 1 >= startAt + CONV + GAP) && (startReq || pend || freeRun)) begin
        startAt = cyc + 1;
        pend = 0;
        sampleNo++;
        adcWord = W'(sampleNo * 157 + 53);
      end else if (startReq) begin
        pend = 1;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    step(1);
    startReq = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    startReq = 1'b0;
    freeRun = 1'b0;
    ctrlWord = '0;
    @(posedge rstN);
    step(4);
    // R2 R3 R4 R5 R6: single request from idle
    ctrlWord = W'(8'hC3);
    pulseStart();
    step(100);
    // R9: requests during conversion and frame collapse into one restart
    ctrlWord = '1;
    pulseStart();
    step(4);
    pulseStart();
    step(CONV + 3);
    pulseStart();
    step(3 * (CONV + GAP));
    // R7 R8 R9: requests landing at many offsets inside the cycle
    for (int k = 0; k < 14; k++) begin
      ctrlWord = W'(k * 29 + 5);
      pulseStart();
      step(CONV + FRAME - 6 + 2 * k);
    end
    step(2 * (CONV + GAP));
    // R10: free-running with a changing control word
    freeRun = 1'b1;
    for (int k = 0; k < 25; k++) begin
      ctrlWord = W'(k * 83 + 17);
      step(17);
    end
    freeRun = 1'b0;
    step(2 * (CONV + GAP));
    // R9 R10: request held high behaves as back-to-back restarts
    ctrlWord = W'(8'h5A);
    startReq = 1'b1;
    step(5 * (CONV + GAP));
    startReq = 1'b0;
    step(2 * (CONV + GAP));
    done = 1'b1;
  end

endmodule

module test_adc_conv_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic doneA, doneB;
  int   extra = 0;

  always #2 clk = ~clk;

  // acquisition limit governs the restart
  seq_harness #(.W(8), .H(2), .CONV(12), .P(3), .A(15), .Q(3)) u_acqBound (
    .clk(clk), .rstN(rstN), .done(doneA));

  // quiet limit governs the restart
  seq_harness #(.W(8), .H(1), .CONV(9), .P(1), .A(2), .Q(6)) u_quietBound (
    .clk(clk), .rstN(rstN), .done(doneB));

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
  end

  initial begin
    int waited;
    waited = 0;
    while (!(doneA === 1'b1 && doneB === 1'b1) && waited < 60000) begin
      @(posedge clk);
      waited++;
    end
    if (!(doneA === 1'b1 && doneB === 1'b1)) begin
      extra = 1;
      $display("FAIL watchdog: run incomplete after %0d cycles, expected completion", waited);
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             u_acqBound.checks + u_quietBound.checks + extra,
             u_acqBound.fails + u_quietBound.fails + extra);
    $finish;
  end

endmodule